// File: doc/BRIEF.md
# Parallel Byte Handshake Receiver

This block sits on the receiving end of an eight-bit parallel link that uses a strobe, an acknowledge line and a busy line. The sender drives a byte onto the data lines and raises strobe. The receiver brings strobe into its own clock domain, latches the data lines and raises acknowledge. Acknowledge stays high until the receiver sees strobe fall, so each byte finishes a full four-phase exchange.

Each captured byte goes into a one-entry output buffer. The buffer presents the byte on a valid/ready interface to the local consumer. Busy is high whenever the receiver cannot take another byte. That covers two cases: a handshake is in progress, or the buffer still holds a byte the consumer has not taken. A stalled consumer therefore holds the sender off.

Top module: `par_byte_rx`

## Requirements
- R1: After reset, `ack_o`, `busy_o` and `rx_valid_o` are all low.
- R2: `ack_o` rises exactly four clock edges after `strb_i` is raised on an idle receiver with an empty buffer. This is two synchronizer edges, one edge to detect strobe and one capture edge. `rx_valid_o` is high when `ack_o` rises.
- R3: Each byte delivered on `rx_data_o` equals the value on `data_i` while strobe was raised. Bytes are delivered once each, in the order they were sent.
- R4: While strobe stays high, `ack_o` stays high once it has risen.
- R5: After strobe is released, `ack_o` falls within five clock cycles. It does not fall while the synchronized strobe is still high.
- R6: While a byte waits in the output buffer, `rx_valid_o` and `busy_o` are both high. `rx_data_o` holds its value until `rx_ready_i` is seen high.
- R7: `busy_o` is low only when the buffer is empty and no handshake is in progress.
- R8: A strobe raised while the buffer is full is not acknowledged until the consumer has taken the buffered byte. The byte on the data lines is then captured and acknowledged.
- R9: Changes on `data_i` after capture, while acknowledge is high, do not alter the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strb_i | input | 1 | Strobe from sender, active high, asynchronous |
| data_i | input | DATA_W | Parallel data lines |
| ack_o | output | 1 | Acknowledge to sender, active high |
| busy_o | output | 1 | Busy to sender, active high |
| rx_data_o | output | DATA_W | Buffered byte to the local consumer |
| rx_valid_o | output | 1 | Buffered byte present |
| rx_ready_i | input | 1 | Consumer accepts the byte when high together with valid |

## Verification
The assertions check, on every cycle, the relations that hold between cycles:
- acknowledge is held while the synchronized strobe is high (R4);
- acknowledge is released once the synchronized strobe falls (R5);
- busy is high whenever the buffer is occupied (R6, R7);
- the buffer stays stable while the consumer stalls (R6);
- valid is present when acknowledge rises (R2).

Only the bench's scenarios can show the remaining behaviour:
- the exact four-cycle latency;
- byte-for-byte order through the scoreboard;
- that data changed after capture is ignored;
- that a strobe raised against a full buffer waits until the consumer drains it.

// File: rtl/par_byte_rx.sv
module par_byte_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);

  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_ACK} state_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   strb_s;
  state_t                 state_q;
  logic                   full_q;
  logic [DATA_W-1:0]      buf_q;
  logic                   take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], strb_i};

  assign strb_s = sync_q[SYNC_STAGES-1];
  assign take   = full_q && rx_ready_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_IDLE;
    else
      case (state_q)
        ST_IDLE: if (strb_s && !full_q) state_q <= ST_CAPT;
        ST_CAPT: state_q <= ST_ACK;
        ST_ACK:  if (!strb_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (state_q == ST_CAPT) begin
      full_q <= 1'b1;
      buf_q  <= data_i;
    end else if (take) begin
      full_q <= 1'b0;
    end

  assign ack_o      = (state_q == ST_ACK);
  assign busy_o     = full_q || (state_q != ST_IDLE);
  assign rx_valid_o = full_q;
  assign rx_data_o  = buf_q;

  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && strb_s) |=> ack_o);

  a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !strb_s) |=> !ack_o);

  a_r2_valid_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> rx_valid_o);

  a_r7_idle_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rx_valid_o && !ack_o));

  a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

endmodule

// File: tb/par_byte_rx_tb.sv
`timescale 1ns/1ps
module par_byte_rx_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strb = 1'b0;
  logic [DW-1:0] data = '0;
  logic          ack, busy, vld;
  logic          rdy = 1'b1;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  par_byte_rx #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .strb_i(strb), .data_i(data),
    .ack_o(ack), .busy_o(busy), .rx_data_o(rdata),
    .rx_valid_o(vld), .rx_ready_i(rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // monitor: pops expected bytes on each accepted transfer (R3)
  always @(negedge clk)
    if (rst_n && vld && rdy) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected byte", rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R3 byte order/value", rdata, e);
      end
    end

  // driver: one full four-phase exchange
  task automatic send(input logic [DW-1:0] d, input bit chk_lat, input int hold);
    int n;
    n = 0;
    while (busy) @(negedge clk);
    data = d; strb = 1'b1;
    exp_q.push_back(d);
    while (!ack) begin @(negedge clk); n++; end
    if (chk_lat) begin
      chk(n == 4, "R2 ack latency", n, 4);
      chk(vld == 1'b1, "R2 valid at ack", vld, 1);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      data = ~d;
      chk(ack == 1'b1, "R4 ack held", ack, 1);
    end
    strb = 1'b0;
    n = 0;
    while (ack && n < 10) begin @(negedge clk); n++; end
    chk(n >= 2 && n <= 5, "R5 ack release", n, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack && !busy && !vld, "R1 reset state", {ack, busy, vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack && !busy && !vld, "R1 after reset", {ack, busy, vld}, 0);

    send(8'hA5, 1, 0);
    send(8'h3C, 1, 3);
    send(8'h00, 1, 1);
    send(8'hFF, 1, 0);
    repeat (4) @(negedge clk);
    chk(!busy, "R7 idle busy low", busy, 0);

    // R9: data flipped during ack hold
    send(8'h5A, 1, 6);
    repeat (2) @(negedge clk);

    // R6/R8: stalled consumer
    rdy = 1'b0;
    send(8'h81, 1, 0);
    repeat (10) @(negedge clk);
    chk(busy && vld, "R6 busy while buffered", {busy, vld}, 3);
    chk(rdata == 8'h81, "R6 held data", rdata, 8'h81);
    data = 8'h42; strb = 1'b1;
    exp_q.push_back(8'h42);
    repeat (20) @(negedge clk);
    chk(ack == 1'b0, "R8 no ack while full", ack, 0);
    chk(rdata == 8'h81, "R8 buffer untouched", rdata, 8'h81);
    rdy = 1'b1;
    begin
      int n;
      n = 0;
      while (!ack && n < 20) begin @(negedge clk); n++; end
      chk(ack == 1'b1, "R8 ack after drain", ack, 1);
      strb = 1'b0;
      n = 0;
      while (ack && n < 10) begin @(negedge clk); n++; end
      chk(!ack, "R5 ack release after drain", ack, 0);
    end

    // toggling ready stream
    for (int k = 0; k < 8; k++) begin
      rdy = k[0];
      send(8'(8'h10 + k * 7), 0, k % 3);
    end
    rdy = 1'b1;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all delivered", exp_q.size(), 0);
    chk(!busy && !vld, "R7 idle at end", {busy, vld}, 0);
    finish_run();
  end
endmodule